// File: doc/BRIEF.md
# Windowed PID Controller for Uncore Voltage/Frequency Level

This block chooses the voltage/frequency level of the shared uncore, which holds the on-chip network and the last-level cache. It makes one decision per fixed window of uncore cycles. The input it regulates is an estimate of the average memory access time. That estimate arrives from elsewhere with a valid strobe and a stale flag. The block compares the estimate with a target and runs a fixed-point proportional-integral-derivative law on the error. It adds the result to the level now in force and issues the next level with a one-cycle update strobe.

The target is a baseline access time plus a tolerated slowdown of about five percent. The tolerance is computed as `base + ((base * TOL_NUM) >> TOL_SHIFT)`, which with the default 13/256 is about 5.08 %. A positive error means memory accesses are slower than allowed, so positive gains raise the level. The integrator saturates at bounds supplied from outside, so a long run against the top or bottom level cannot wind it up. The derivative term uses the error from the last window that was evaluated, so a sudden jump in access time moves the level in the update that closes that window.

`rst_n` is taken to be already synchronised to `clk`. The window counter starts at zero when reset is released.

Top module: `uncore_pid_dvfs`

## Requirements
- R1: While `rst_n` is low, `lvl_upd` is 0 and `nxt_level` is 0.
- R2: The window is `WIN_LEN` cycles long. The first window begins on the cycle after reset release. `lvl_upd` is high for exactly one cycle, two cycles after the last cycle of a window that ends with a fresh sample, and is low at all other times.
- R3: The error is `est_amat - (base_amat + ((base_amat*13)>>8))`, formed with the estimate and baseline treated as unsigned. It is saturated to the signed 16-bit range [-32768, 32767].
- R4: The new integrator value is `integ + err`, clamped to [`int_lo`, `int_hi`] (both signed 16-bit). Above `int_hi` it becomes `int_hi`; otherwise, below `int_lo` it becomes `int_lo`. It starts at 0 after reset.
- R5: The derivative input is `err` minus the error of the previous evaluated window. That previous error is 0 after reset.
- R6: Let `u = kp*err + ki*integ_new + kd*deriv`, where the gains are signed 8-bit values. The next level is `cur_level + floor(u / 256)`, clamped to the range 0 to 7.
- R7: If the effective sample of a window is stale, or no `est_vld` strobe arrives in the window, there is no update. In that case the integrator and the previous error are left unchanged.
- R8: When `est_vld` pulses more than once in a window, the last pulse decides both the value and the stale flag. A pulse on the last cycle of the window counts.
- R9: `nxt_level` changes only in a cycle in which `lvl_upd` is high.
- R10: When the gains are positive and the access time rises sharply above target, the update that closes that window raises the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Uncore clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| est_vld | input | 1 | Strobe: `est_amat` and `est_stale` are valid this cycle |
| est_stale | input | 1 | Marks the strobed estimate as stale |
| est_amat | input | DATA_W | Estimated average memory access time, unsigned |
| base_amat | input | DATA_W | Baseline access time, unsigned; sampled on the last cycle of the window |
| kp | input | GAIN_W | Proportional gain, signed |
| ki | input | GAIN_W | Integral gain, signed |
| kd | input | GAIN_W | Derivative gain, signed |
| int_lo | input | DATA_W | Integrator lower bound, signed |
| int_hi | input | DATA_W | Integrator upper bound, signed |
| cur_level | input | LVL_W | Level now in force |
| lvl_upd | output | 1 | One-cycle strobe: a new level is issued |
| nxt_level | output | LVL_W | Next level; held between updates |

## Verification
The error is registered on the clock edge that ends the window's last cycle. The level and the strobe are registered on the edge after that. Both results therefore appear in the second cycle after the window's final cycle, which is the second cycle of the next window. Inputs are driven on falling edges in step with a counter in the bench that tracks the window. The bench compares `lvl_upd` and `nxt_level` with its arithmetic model in every cycle of every window, and expects the strobe only in that second cycle. The gains, bounds and current level are changed only from the third cycle of a window onward, so the values the model uses are the ones in place on the edge where the law is evaluated.

// File: rtl/uncore_pid_dvfs_pkg.sv
package uncore_pid_dvfs_pkg;
  localparam int DEF_WIN_LEN   = 50000;
  localparam int DEF_DATA_W    = 16;
  localparam int DEF_GAIN_W    = 8;
  localparam int DEF_LVL_W     = 3;
  localparam int DEF_TOL_NUM   = 13;
  localparam int DEF_TOL_SHIFT = 8;
  localparam int DEF_OUT_SHIFT = 8;
endpackage

// File: rtl/dvfs_win_timer.sv
module dvfs_win_timer #(
  parameter int WIN_LEN = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_last
);
  localparam int CNT_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    win_last = (cnt_q == LAST);
    cnt_d    = win_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dvfs_err_stage.sv
module dvfs_err_stage #(
  parameter int DATA_W    = 16,
  parameter int TOL_NUM   = 13,
  parameter int TOL_SHIFT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     win_last,
  input  logic                     est_vld,
  input  logic                     est_stale,
  input  logic [DATA_W-1:0]        est_amat,
  input  logic [DATA_W-1:0]        base_amat,
  output logic                     sample_ok,
  output logic                     eval_q,
  output logic signed [DATA_W-1:0] err_q
);
  localparam int TNUM_W = $clog2(TOL_NUM + 1);
  localparam int MUL_W  = DATA_W + TNUM_W;
  localparam int EXT_W  = DATA_W + 2;
  localparam int DIF_W  = EXT_W + 1;
  localparam logic signed [DIF_W-1:0] POS_LIM = DIF_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [DIF_W-1:0] NEG_LIM = ~POS_LIM;

  logic [DATA_W-1:0] held_q;
  logic              have_q, stale_q;
  logic              have_d;

  logic [DATA_W-1:0]        eff_val;
  logic                     eff_have, eff_stale;
  logic [MUL_W-1:0]         tol_prod;
  logic [EXT_W-1:0]         ref_u;
  logic signed [DIF_W-1:0]  diff;
  logic signed [DATA_W-1:0] err_d;
  logic                     eval_d;

  // a strobe in the same cycle overrides what is held (last strobe wins)
  always_comb begin
    eff_have  = est_vld | have_q;
    eff_stale = est_vld ? est_stale : stale_q;
    eff_val   = est_vld ? est_amat  : held_q;
    sample_ok = eff_have & ~eff_stale;
    have_d    = win_last ? 1'b0 : eff_have;
  end

  always_comb begin
    tol_prod = MUL_W'(base_amat) * MUL_W'(TOL_NUM);
    ref_u    = EXT_W'(base_amat) + EXT_W'(tol_prod >> TOL_SHIFT);
    diff     = $signed({1'b0, EXT_W'(eff_val)}) - $signed({1'b0, ref_u});
    if (diff > POS_LIM)      err_d = POS_LIM[DATA_W-1:0];
    else if (diff < NEG_LIM) err_d = NEG_LIM[DATA_W-1:0];
    else                     err_d = diff[DATA_W-1:0];
    eval_d = win_last & sample_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= '0;
      stale_q <= 1'b0;
    end else if (est_vld) begin
      held_q  <= est_amat;
      stale_q <= est_stale;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      eval_q <= 1'b0;
    end else begin
      have_q <= have_d;
      eval_q <= eval_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= '0;
    else if (eval_d) err_q <= err_d;
  end
endmodule

// File: rtl/dvfs_pid_law.sv
module dvfs_pid_law #(
  parameter int DATA_W    = 16,
  parameter int GAIN_W    = 8,
  parameter int LVL_W     = 3,
  parameter int OUT_SHIFT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     eval,
  input  logic signed [DATA_W-1:0] err,
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic signed [GAIN_W-1:0] kd,
  input  logic signed [DATA_W-1:0] int_lo,
  input  logic signed [DATA_W-1:0] int_hi,
  input  logic [LVL_W-1:0]         cur_level,
  output logic                     lvl_upd,
  output logic [LVL_W-1:0]         nxt_level,
  output logic signed [DATA_W-1:0] integ_q
);
  localparam int EXT_W = DATA_W + 1;
  localparam int SUM_W = GAIN_W + DATA_W + 3;
  localparam logic signed [SUM_W-1:0] LVL_TOP = SUM_W'((1 << LVL_W) - 1);

  logic signed [DATA_W-1:0] eprev_q;
  logic [LVL_W-1:0]         lvl_q, lvl_d;
  logic                     upd_q;

  logic signed [EXT_W-1:0]  isum, hi_x, lo_x, deriv;
  logic signed [DATA_W-1:0] inew;
  logic signed [SUM_W-1:0]  kp_x, ki_x, kd_x, err_x, int_x, der_x;
  logic signed [SUM_W-1:0]  u_sum, delta, step;

  always_comb begin
    isum  = {integ_q[DATA_W-1], integ_q} + {err[DATA_W-1], err};
    hi_x  = {int_hi[DATA_W-1], int_hi};
    lo_x  = {int_lo[DATA_W-1], int_lo};
    if (isum > hi_x)      inew = int_hi;
    else if (isum < lo_x) inew = int_lo;
    else                  inew = isum[DATA_W-1:0];
    deriv = {err[DATA_W-1], err} - {eprev_q[DATA_W-1], eprev_q};
  end

  always_comb begin
    kp_x  = {{(SUM_W-GAIN_W){kp[GAIN_W-1]}}, kp};
    ki_x  = {{(SUM_W-GAIN_W){ki[GAIN_W-1]}}, ki};
    kd_x  = {{(SUM_W-GAIN_W){kd[GAIN_W-1]}}, kd};
    err_x = {{(SUM_W-DATA_W){err[DATA_W-1]}}, err};
    int_x = {{(SUM_W-DATA_W){inew[DATA_W-1]}}, inew};
    der_x = {{(SUM_W-EXT_W){deriv[EXT_W-1]}}, deriv};
    u_sum = kp_x * err_x + ki_x * int_x + kd_x * der_x;
    delta = u_sum >>> OUT_SHIFT;
    step  = {{(SUM_W-LVL_W){1'b0}}, cur_level} + delta;
    if (step < 0)            lvl_d = '0;
    else if (step > LVL_TOP) lvl_d = LVL_TOP[LVL_W-1:0];
    else                     lvl_d = step[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      eprev_q <= '0;
      lvl_q   <= '0;
    end else if (eval) begin
      integ_q <= inew;
      eprev_q <= err;
      lvl_q   <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= eval;
  end

  assign lvl_upd   = upd_q;
  assign nxt_level = lvl_q;
endmodule

// File: rtl/uncore_pid_dvfs.sv
module uncore_pid_dvfs
  import uncore_pid_dvfs_pkg::*;
#(
  parameter int WIN_LEN   = DEF_WIN_LEN,
  parameter int DATA_W    = DEF_DATA_W,
  parameter int GAIN_W    = DEF_GAIN_W,
  parameter int LVL_W     = DEF_LVL_W,
  parameter int TOL_NUM   = DEF_TOL_NUM,
  parameter int TOL_SHIFT = DEF_TOL_SHIFT,
  parameter int OUT_SHIFT = DEF_OUT_SHIFT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     est_vld,
  input  logic                     est_stale,
  input  logic [DATA_W-1:0]        est_amat,
  input  logic [DATA_W-1:0]        base_amat,
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic signed [GAIN_W-1:0] kd,
  input  logic signed [DATA_W-1:0] int_lo,
  input  logic signed [DATA_W-1:0] int_hi,
  input  logic [LVL_W-1:0]         cur_level,
  output logic                     lvl_upd,
  output logic [LVL_W-1:0]         nxt_level
);
  logic                     win_last;
  logic                     sample_ok;
  logic                     eval_q;
  logic signed [DATA_W-1:0] err_q;
  logic signed [DATA_W-1:0] integ_q;

  dvfs_win_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_last (win_last)
  );

  dvfs_err_stage #(
    .DATA_W(DATA_W), .TOL_NUM(TOL_NUM), .TOL_SHIFT(TOL_SHIFT)
  ) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_last  (win_last),
    .est_vld   (est_vld),
    .est_stale (est_stale),
    .est_amat  (est_amat),
    .base_amat (base_amat),
    .sample_ok (sample_ok),
    .eval_q    (eval_q),
    .err_q     (err_q)
  );

  dvfs_pid_law #(
    .DATA_W(DATA_W), .GAIN_W(GAIN_W), .LVL_W(LVL_W), .OUT_SHIFT(OUT_SHIFT)
  ) u_law (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval      (eval_q),
    .err       (err_q),
    .kp        (kp),
    .ki        (ki),
    .kd        (kd),
    .int_lo    (int_lo),
    .int_hi    (int_hi),
    .cur_level (cur_level),
    .lvl_upd   (lvl_upd),
    .nxt_level (nxt_level),
    .integ_q   (integ_q)
  );
endmodule

// File: rtl/uncore_pid_dvfs_chk.sv
module uncore_pid_dvfs_chk #(
  parameter int DATA_W = 16,
  parameter int LVL_W  = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lvl_upd,
  input logic [LVL_W-1:0]         nxt_level,
  input logic                     win_last,
  input logic                     sample_ok,
  input logic                     eval_q,
  input logic signed [DATA_W-1:0] integ_q,
  input logic signed [DATA_W-1:0] int_lo,
  input logic signed [DATA_W-1:0] int_hi
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (lvl_upd == 1'b0 && nxt_level == '0);
    end
  end

  // R2
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_upd |=> !lvl_upd);

  // R2
  upd_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_upd |-> $past(win_last, 2));

  // R7
  stale_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(win_last, 2) && !$past(sample_ok, 2)) |-> !lvl_upd);

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_upd |-> $stable(nxt_level));

  // R4
  integ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_q && (int_lo <= int_hi)) |=>
      (integ_q >= $past(int_lo) && integ_q <= $past(int_hi)));
endmodule

bind uncore_pid_dvfs uncore_pid_dvfs_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lvl_upd   (lvl_upd),
  .nxt_level (nxt_level),
  .win_last  (win_last),
  .sample_ok (sample_ok),
  .eval_q    (eval_q),
  .integ_q   (integ_q),
  .int_lo    (int_lo),
  .int_hi    (int_hi)
);

// File: tb/test_uncore_pid_dvfs.sv
module test_uncore_pid_dvfs;
  localparam int W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              est_vld, est_stale;
  logic [15:0]       est_amat, base_amat;
  logic signed [7:0] kp, ki, kd;
  logic signed [15:0] int_lo, int_hi;
  logic [2:0]        cur_level;
  logic              lvl_upd;
  logic [2:0]        nxt_level;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  int g_base, g_kp, g_ki, g_kd, g_lo, g_hi, g_cur;
  int m_integ, m_eprev, m_lvl, shown_lvl;
  bit pend_upd;

  always #4 clk = ~clk;

  uncore_pid_dvfs #(.WIN_LEN(W)) i_uncore_pid_dvfs (
    .clk(clk), .rst_n(rst_n), .est_vld(est_vld), .est_stale(est_stale),
    .est_amat(est_amat), .base_amat(base_amat), .kp(kp), .ki(ki), .kd(kd),
    .int_lo(int_lo), .int_hi(int_hi), .cur_level(cur_level),
    .lvl_upd(lvl_upd), .nxt_level(nxt_level)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // one window; strobe a at cycle at_a, strobe b at cycle at_b (-1 = none)
  task automatic run_win(input int est_a, input bit st_a, input int at_a,
                         input int est_b, input bit st_b, input int at_b);
    int base_l = 0, kp_l = 0, ki_l = 0, kd_l = 0, lo_l = 0, hi_l = 0, cur_l = 0;
    int eff_est = 0;
    bit have = 0, eff_st = 0;
    for (int i = 0; i < W; i++) begin
      if (i == 1) begin
        shown_lvl = m_lvl;
        // R2: strobe due two cycles after previous window's last cycle
        chk(lvl_upd == pend_upd, "R2 update strobe", int'(lvl_upd), int'(pend_upd));
        if (pend_upd)
          chk(nxt_level == 3'(shown_lvl), "R6 next level", int'(nxt_level), shown_lvl);
        else
          chk(nxt_level == 3'(shown_lvl), "R7 level unchanged", int'(nxt_level), shown_lvl);
      end else begin
        chk(lvl_upd == 1'b0, "R2 no strobe off-slot", int'(lvl_upd), 0);
        chk(nxt_level == 3'(shown_lvl), "R9 level held", int'(nxt_level), shown_lvl);
      end
      if (i == 2) begin
        base_amat = 16'(g_base); kp = 8'(g_kp); ki = 8'(g_ki); kd = 8'(g_kd);
        int_lo = 16'(g_lo); int_hi = 16'(g_hi); cur_level = 3'(g_cur);
        base_l = g_base; kp_l = g_kp; ki_l = g_ki; kd_l = g_kd;
        lo_l = g_lo; hi_l = g_hi; cur_l = g_cur;
      end
      est_vld = 1'b0; est_stale = 1'b0;
      if (i == at_a) begin
        est_vld = 1'b1; est_stale = st_a; est_amat = 16'(est_a);
        have = 1; eff_st = st_a; eff_est = est_a;
      end
      if (i == at_b) begin
        est_vld = 1'b1; est_stale = st_b; est_amat = 16'(est_b);
        have = 1; eff_st = st_b; eff_est = est_b;
      end
      @(negedge clk);
    end
    est_vld = 1'b0; est_stale = 1'b0;
    pend_upd = have && !eff_st;
    if (pend_upd) begin
      int rf, e, isum, inew, d, u, dl, lv;
      rf = base_l + ((base_l * 13) >>> 8);
      e = sat16(eff_est - rf);
      isum = m_integ + e;
      if (isum > hi_l) inew = hi_l;
      else if (isum < lo_l) inew = lo_l;
      else inew = isum;
      d = e - m_eprev;
      u = kp_l * e + ki_l * inew + kd_l * d;
      dl = u >>> 8;
      lv = cur_l + dl;
      if (lv < 0) lv = 0;
      if (lv > 7) lv = 7;
      m_integ = inew; m_eprev = e; m_lvl = lv;
    end
  endtask

  task automatic win1(input int est);
    run_win(est, 0, 3, 0, 0, -1);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; est_vld = 1'b0; est_stale = 1'b0; est_amat = '0; base_amat = '0;
    kp = '0; ki = '0; kd = '0; int_lo = '0; int_hi = '0; cur_level = '0;
    m_integ = 0; m_eprev = 0; m_lvl = 0; shown_lvl = 0; pend_upd = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(lvl_upd == 1'b0, "R1 reset strobe", int'(lvl_upd), 0);
    chk(nxt_level == 3'd0, "R1 reset level", int'(nxt_level), 0);
    rst_n = 1'b1;

    // R6/R10 sweep: proportional only, ref = 1050
    g_base = 1000; g_kp = 16; g_ki = 0; g_kd = 0; g_lo = -32768; g_hi = 32767;
    for (int c = 0; c < 8; c++) begin
      for (int k = -9; k <= 9; k++) begin
        g_cur = c;
        win1(1050 + 16 * k + ((c + k + 20) % 16));
      end
    end
    // R10: sharp rise from on-target
    g_cur = 2; win1(1050); win1(1250);

    // R4: integrator clamp
    g_kp = 0; g_ki = 16; g_kd = 0; g_lo = -40; g_hi = 40; g_cur = 3;
    for (int n = 0; n < 3; n++) win1(1080);
    win1(950); win1(950); win1(1060);

    // R5: derivative against previous evaluated error
    g_ki = 0; g_kd = 16; g_cur = 4;
    win1(1050); win1(1114); win1(1114); win1(1018); win1(1050);

    // R7: stale sample and missing strobe, then a fresh window
    g_kp = 16; g_ki = 4; g_kd = 8; g_lo = -500; g_hi = 500; g_cur = 5;
    run_win(3000, 1, 4, 0, 0, -1);
    run_win(0, 0, -1, 0, 0, -1);
    win1(1100);

    // R8: last strobe wins; strobe on final cycle counts
    run_win(1400, 0, 1, 900, 1, 5);
    run_win(1400, 1, 0, 1000, 0, W - 1);
    run_win(900, 0, 2, 1300, 0, 6);

    // R3: saturation of the error and a wide reference
    g_kp = 1; g_ki = 0; g_kd = 0; g_base = 0; g_cur = 0;
    win1(65535);
    g_base = 65535; g_cur = 7;
    win1(0);
    g_base = 1000; g_cur = 3; g_kp = 16;
    win1(1050);

    // mixed sweep across all terms
    for (int n = 0; n < 40; n++) begin
      g_kp = (n * 5) % 31 - 8; g_ki = (n * 3) % 9 - 2; g_kd = n % 7 - 3;
      g_lo = -500; g_hi = 700; g_cur = n % 8; g_base = 800 + n * 11;
      run_win(g_base + (n * 53) % 400 - 150, (n % 9) == 4, n % W, 0, 0, -1);
    end

    run_win(0, 0, -1, 0, 0, -1);
    finished = 1;
    report();
  end
endmodule